// File: doc/BRIEF.md
# MII Receive Frame Capture

This block sits on the receive clock of a media-independent interface PHY. It takes the 4-bit receive nibbles, looks for the start-of-frame delimiter inside the preamble, and packs the nibbles that follow into bytes. The bytes leave as a stream with a valid strobe and first-byte and last-byte markers. A two-bit status goes with the last byte: a receive-error flag and a misalignment flag. Nibbles are taken only while data-valid is high. Anything presented while data-valid is low, including error codes, is ignored.

The receive clock runs at 2.5 MHz for 10 Mbps and at 25 MHz for 100 Mbps. The block works on the clock edges alone, so one design serves both rates. The carrier-sense and collision inputs are asynchronous to this clock. They come out through a synchroniser chain so that downstream logic can use them. CRC checking and the hand-off to a system clock domain are done elsewhere.

Top module: `mii_rx_capture`

## Requirements
- R1: A nibble is taken on a rising edge of `rxClk` only when `rxDv` is high. Each data byte is built from two nibbles, least-significant nibble first: byte = {second nibble, first nibble}.
- R2: Byte packing starts right after the delimiter. The delimiter is a nibble 0xD taken while `rxDv` is high, where the nibble before it in the same frame was 0x5. A frame with no delimiter produces no output.
- R3: `rxSof` is high together with `rxByteValid` for the first data byte of each frame, and only for that byte.
- R4: `rxEof` is high together with `rxByteValid` for the last complete data byte. It appears in the cycle after the edge that samples `rxDv` low. `rxCrcErr` and `rxAlignErr` can be high only together with `rxEof`.
- R5: If `rxEr` is high on any edge where `rxDv` is high during a frame, including the preamble, `rxCrcErr` is set with that frame's `rxEof`.
- R6: While `rxDv` is low, `rxd` and `rxEr` have no effect. No byte is produced, and the error status of the next frame is not affected.
- R7: A frame with an odd number of nibbles after the delimiter reports `rxAlignErr` with its `rxEof`. The last unpaired nibble is dropped.
- R8: Bytes that are not the last byte of a frame are never presented on two consecutive cycles.
- R9: `crsSync` and `colSync` follow `crsIn` and `colIn` with a delay of exactly two `rxClk` edges.
- R10: While reset is asserted and right after it, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rxClk | input | 1 | Receive nibble clock (2.5 or 25 MHz) |
| rxRstN | input | 1 | Asynchronous active-low reset |
| rxDv | input | 1 | Receive data valid |
| rxEr | input | 1 | Receive coding error |
| rxd | input | 4 | Receive nibble |
| crsIn | input | 1 | Asynchronous carrier sense |
| colIn | input | 1 | Asynchronous collision |
| rxByte | output | 8 | Assembled data byte |
| rxByteValid | output | 1 | Byte strobe |
| rxSof | output | 1 | First byte of frame |
| rxEof | output | 1 | Last byte of frame |
| rxCrcErr | output | 1 | Frame saw a receive error (with rxEof) |
| rxAlignErr | output | 1 | Odd nibble count after delimiter (with rxEof) |
| crsSync | output | 1 | Synchronised carrier sense |
| colSync | output | 1 | Synchronised collision |

## Verification
The hardest case to create is the end-of-frame timing. The last byte is held back until data-valid is seen low, so its marker shows up a full cycle after the final nibble. It must also come out right for frames that end on an odd nibble or after only one byte. The stimulus sends frames whose data-valid falls just after a completed byte, just after an unpaired nibble, and after a single byte. The bench records the cycle of the falling edge and compares it with the cycle in which the end marker appears. Two frames are also sent back to back with a one-cycle gap. This shows that the end of the first frame and the delimiter hunt of the second do not interfere.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

  typedef enum logic [1:0] {
    S_HUNT = 2'd0,
    S_LOW  = 2'd1,
    S_HIGH = 2'd2
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLow;
    logic packByte;
    logic emitMid;
    logic emitLast;
    logic markSof;
    logic markAlign;
    logic clearFrame;
  } rxStrobe_t;

endpackage

// File: rtl/mii_rx_sync.sv
module mii_rx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] warm;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            warm <= '0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
      end
      p_sync_delay_r9: assert property (@(posedge clk) disable iff (!rstN)
        (warm == 2'd2) |-> (syncOut == $past(asyncIn, 2)));
    end
  endgenerate

endmodule

// File: rtl/mii_rx_ctrl.sv
module mii_rx_ctrl
  import mii_rx_pkg::*;
#(
  parameter int                    NIB_W    = 4,
  parameter logic [2*NIB_W-1:0]    SFD_BYTE = 8'hD5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxDv,
  input  logic [NIB_W-1:0] rxNib,
  output rxStrobe_t        strobe
);

  localparam logic [NIB_W-1:0] PRE_NIB = SFD_BYTE[NIB_W-1:0];
  localparam logic [NIB_W-1:0] SFD_NIB = SFD_BYTE[2*NIB_W-1:NIB_W];

  rxState_t state, stateNext;
  logic     prevPre;
  logic     havePend;
  logic     firstPend;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (rxDv) begin
      case (state)
        S_HUNT: if (prevPre && rxNib == SFD_NIB) stateNext = S_LOW;
        S_LOW: begin
          strobe.loadLow = 1'b1;
          stateNext      = S_HIGH;
        end
        S_HIGH: begin
          strobe.packByte = 1'b1;
          strobe.emitMid  = havePend;
          strobe.markSof  = firstPend;
          stateNext       = S_LOW;
        end
        default: stateNext = S_HUNT;
      endcase
    end else begin
      strobe.clearFrame = 1'b1;
      stateNext         = S_HUNT;
      if (state != S_HUNT && havePend) begin
        strobe.emitLast  = 1'b1;
        strobe.markSof   = firstPend;
        strobe.markAlign = (state == S_HIGH);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_HUNT;
      prevPre   <= 1'b0;
      havePend  <= 1'b0;
      firstPend <= 1'b0;
    end else begin
      state   <= stateNext;
      prevPre <= rxDv && (state == S_HUNT) && (rxNib == PRE_NIB);
      if (strobe.clearFrame) begin
        havePend  <= 1'b0;
        firstPend <= 1'b0;
      end else if (strobe.packByte) begin
        havePend  <= 1'b1;
        firstPend <= !havePend;
      end
    end
  end

  p_hunt_after_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rxDv |=> (state == S_HUNT));

  p_hunt_clean_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HUNT) |-> (!havePend && !firstPend));

  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    state inside {S_HUNT, S_LOW, S_HIGH});

endmodule

// File: rtl/mii_rx_dp.sv
module mii_rx_dp
  import mii_rx_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxDv,
  input  logic               rxEr,
  input  logic [NIB_W-1:0]   rxNib,
  input  rxStrobe_t          strobe,
  output logic [2*NIB_W-1:0] outData,
  output logic               outValid,
  output logic               outSof,
  output logic               outEof,
  output logic               outCrcErr,
  output logic               outAlignErr
);

  localparam int BYTE_W = 2 * NIB_W;

  logic [NIB_W-1:0]  lowNib;
  logic [BYTE_W-1:0] pendByte;
  logic              errSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowNib   <= '0;
      pendByte <= '0;
      errSeen  <= 1'b0;
    end else begin
      if (strobe.loadLow)  lowNib   <= rxNib;
      if (strobe.packByte) pendByte <= {rxNib, lowNib};
      if (strobe.clearFrame)   errSeen <= 1'b0;
      else if (rxDv && rxEr)   errSeen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData     <= '0;
      outValid    <= 1'b0;
      outSof      <= 1'b0;
      outEof      <= 1'b0;
      outCrcErr   <= 1'b0;
      outAlignErr <= 1'b0;
    end else begin
      outValid    <= 1'b0;
      outSof      <= 1'b0;
      outEof      <= 1'b0;
      outCrcErr   <= 1'b0;
      outAlignErr <= 1'b0;
      if (strobe.emitMid || strobe.emitLast) begin
        outData  <= pendByte;
        outValid <= 1'b1;
        outSof   <= strobe.markSof;
      end
      if (strobe.emitLast) begin
        outEof      <= 1'b1;
        outCrcErr   <= errSeen;
        outAlignErr <= strobe.markAlign;
      end
    end
  end

  p_status_with_eof_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outCrcErr || outAlignErr) |-> outEof);

  p_marker_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outSof || outEof) |-> outValid);

  p_byte_spacing_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outEof) |=> (!outValid || outEof));

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxDv && rxEr) |=> errSeen);

endmodule

// File: rtl/mii_rx_capture.sv
module mii_rx_capture
  import mii_rx_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               rxClk,
  input  logic               rxRstN,
  input  logic               rxDv,
  input  logic               rxEr,
  input  logic [NIB_W-1:0]   rxd,
  input  logic               crsIn,
  input  logic               colIn,
  output logic [2*NIB_W-1:0] rxByte,
  output logic               rxByteValid,
  output logic               rxSof,
  output logic               rxEof,
  output logic               rxCrcErr,
  output logic               rxAlignErr,
  output logic               crsSync,
  output logic               colSync
);

  rxStrobe_t strobe;

  mii_rx_ctrl #(.NIB_W(NIB_W)) u_ctrl (
    .clk    (rxClk),
    .rstN   (rxRstN),
    .rxDv   (rxDv),
    .rxNib  (rxd),
    .strobe (strobe)
  );

  mii_rx_dp #(.NIB_W(NIB_W)) u_dp (
    .clk         (rxClk),
    .rstN        (rxRstN),
    .rxDv        (rxDv),
    .rxEr        (rxEr),
    .rxNib       (rxd),
    .strobe      (strobe),
    .outData     (rxByte),
    .outValid    (rxByteValid),
    .outSof      (rxSof),
    .outEof      (rxEof),
    .outCrcErr   (rxCrcErr),
    .outAlignErr (rxAlignErr)
  );

  mii_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk     (rxClk),
    .rstN    (rxRstN),
    .asyncIn ({colIn, crsIn}),
    .syncOut ({colSync, crsSync})
  );

endmodule

// File: tb/tb_mii_rx_capture.sv
`timescale 1ns/1ps
module tb_mii_rx_capture;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxDv = 1'b0, rxEr = 1'b0, crsIn = 1'b0, colIn = 1'b0;
  logic [3:0] rxd = 4'h0;
  logic [7:0] rxByte;
  logic       rxByteValid, rxSof, rxEof, rxCrcErr, rxAlignErr, crsSync, colSync;

  always #2.5 clk = ~clk;

  mii_rx_capture dut (
    .rxClk(clk), .rxRstN(rstN), .rxDv(rxDv), .rxEr(rxEr), .rxd(rxd),
    .crsIn(crsIn), .colIn(colIn), .rxByte(rxByte), .rxByteValid(rxByteValid),
    .rxSof(rxSof), .rxEof(rxEof), .rxCrcErr(rxCrcErr), .rxAlignErr(rxAlignErr),
    .crsSync(crsSync), .colSync(colSync)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  bit finished = 0;

  // recorded output stream
  logic [7:0] recData [0:255];
  logic       recSof [0:255], recEof [0:255], recCrc [0:255], recAlign [0:255];
  int         recCyc [0:255];
  int         recCount = 0;
  // expected stream
  logic [7:0] expData [0:255];
  logic       expSof [0:255], expEof [0:255], expCrc [0:255], expAlign [0:255];
  int         expCyc [0:255];
  int         expCount = 0;

  logic [3:0] nibBuf [0:127];
  int         nibN = 0;
  int         lastEnd = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (rxByteValid && recCount < 256) begin
      recData[recCount]  = rxByte;
      recSof[recCount]   = rxSof;
      recEof[recCount]   = rxEof;
      recCrc[recCount]   = rxCrcErr;
      recAlign[recCount] = rxAlignErr;
      recCyc[recCount]   = cyc;
      recCount++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearAll();
    recCount = 0;
    expCount = 0;
  endtask

  task automatic fillFrame(input int preN, input int dataNibs, input int seed);
    nibN = 0;
    for (int i = 0; i < preN; i++) begin nibBuf[nibN] = 4'h5; nibN++; end
    nibBuf[nibN] = 4'hD; nibN++;
    for (int i = 0; i < dataNibs; i++) begin
      nibBuf[nibN] = 4'((seed + i * 7 + i / 3) % 16); nibN++;
    end
  endtask

  // drive nibBuf with rxDv high; errAt marks the nibble with rxEr (-1 none)
  task automatic driveFrame(input int errAt);
    for (int i = 0; i < nibN; i++) begin
      @(negedge clk);
      rxDv = 1'b1; rxd = nibBuf[i]; rxEr = (i == errAt);
    end
    @(negedge clk);
    rxDv = 1'b0; rxEr = 1'b0; rxd = 4'h0;
    lastEnd = cyc + 1;
  endtask

  // expected model: R1, R2, R3, R4, R5, R7
  task automatic addExpected(input bit anyErr);
    int s = -1, m, nb;
    for (int i = 1; i < nibN; i++)
      if (s < 0 && nibBuf[i] == 4'hD && nibBuf[i-1] == 4'h5) s = i + 1;
    if (s < 0) return;
    m  = nibN - s;
    nb = m / 2;
    for (int j = 0; j < nb; j++) begin
      expData[expCount]  = {nibBuf[s+2*j+1], nibBuf[s+2*j]};
      expSof[expCount]   = (j == 0);
      expEof[expCount]   = (j == nb - 1);
      expCrc[expCount]   = (j == nb - 1) && anyErr;
      expAlign[expCount] = (j == nb - 1) && (m % 2 == 1);
      expCyc[expCount]   = (j == nb - 1) ? lastEnd : -1;
      expCount++;
    end
  endtask

  task automatic compareAll(input string req);
    chk(recCount == expCount, req, "byte count", recCount, expCount);
    for (int j = 0; j < expCount && j < recCount; j++) begin
      chk(recData[j] == expData[j], "R1", "byte", recData[j], expData[j]);
      chk(recSof[j] == expSof[j], "R3", "sof", recSof[j], expSof[j]);
      chk(recEof[j] == expEof[j], "R4", "eof", recEof[j], expEof[j]);
      chk(recCrc[j] == expCrc[j], "R5", "crc status", recCrc[j], expCrc[j]);
      chk(recAlign[j] == expAlign[j], "R7", "align status", recAlign[j], expAlign[j]);
      if (expCyc[j] >= 0)
        chk(recCyc[j] == expCyc[j], "R4", "eof cycle", recCyc[j], expCyc[j]);
      if (j > 0 && !recEof[j])
        chk(recCyc[j] - recCyc[j-1] >= 2, "R8", "byte spacing",
            recCyc[j] - recCyc[j-1], 2);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    crsIn = 1'b1; colIn = 1'b1; rxDv = 1'b1; rxd = 4'hD; rxEr = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(!rxByteValid && !rxSof && !rxEof && !rxCrcErr && !rxAlignErr, "R10",
        "outputs in reset", {rxByteValid, rxSof, rxEof, rxCrcErr, rxAlignErr}, 0);
    chk(!crsSync && !colSync && rxByte == 8'h0, "R10", "sync/data in reset",
        {crsSync, colSync, rxByte}, 0);
    @(negedge clk);
    rxDv = 1'b0; rxd = 4'h0; rxEr = 1'b0; crsIn = 1'b0; colIn = 1'b0;
    rstN = 1'b1;
    @(posedge clk); #1;
    chk(!rxByteValid && !crsSync && !colSync, "R10", "outputs after reset",
        {rxByteValid, crsSync, colSync}, 0);
  endtask

  task automatic testBasic();
    clearAll();
    fillFrame(15, 16, 3);
    driveFrame(-1);
    addExpected(1'b0);
    idle(4);
    compareAll("R2");
  endtask

  task automatic testRxErr();
    clearAll();
    fillFrame(7, 12, 9);
    driveFrame(12);
    addExpected(1'b1);
    idle(4);
    compareAll("R5");
    clearAll();
    fillFrame(7, 6, 1);
    driveFrame(3);  // error during preamble
    addExpected(1'b1);
    idle(4);
    compareAll("R5");
  endtask

  task automatic testOdd();
    clearAll();
    fillFrame(5, 9, 4);
    driveFrame(-1);
    addExpected(1'b0);
    idle(4);
    compareAll("R7");
  endtask

  task automatic testNoSfd();
    clearAll();
    nibN = 0;
    for (int i = 0; i < 20; i++) begin nibBuf[nibN] = (i % 3 == 0) ? 4'hD : 4'hA; nibN++; end
    driveFrame(-1);
    idle(4);
    chk(recCount == 0, "R2", "no delimiter output count", recCount, 0);
  endtask

  task automatic testIgnoreIdle();
    clearAll();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      rxDv = 1'b0; rxEr = 1'b1; rxd = (i < 6) ? 4'h5 : ((i == 6) ? 4'hD : 4'(i));
    end
    @(negedge clk); rxEr = 1'b0; rxd = 4'h0;
    idle(3);
    chk(recCount == 0, "R6", "output while data-valid low", recCount, 0);
    fillFrame(3, 8, 6);
    driveFrame(-1);
    addExpected(1'b0);
    idle(4);
    compareAll("R6");
  endtask

  task automatic testSingleByte();
    clearAll();
    fillFrame(2, 2, 11);
    driveFrame(-1);
    addExpected(1'b0);
    idle(4);
    compareAll("R3");
    chk(recCount == 1 && recSof[0] && recEof[0], "R3", "single byte sof+eof",
        recCount, 1);
  endtask

  task automatic testBackToBack();
    clearAll();
    fillFrame(6, 10, 2);
    driveFrame(-1);
    addExpected(1'b0);
    fillFrame(4, 7, 13);
    driveFrame(5);
    addExpected(1'b1);
    idle(4);
    compareAll("R8");
  endtask

  task automatic testSync();
    @(negedge clk); crsIn = 1'b1;
    @(posedge clk); #1;
    chk(crsSync == 1'b0, "R9", "crs after one edge", crsSync, 0);
    @(posedge clk); #1;
    chk(crsSync == 1'b1, "R9", "crs after two edges", crsSync, 1);
    @(negedge clk); colIn = 1'b1; crsIn = 1'b0;
    @(posedge clk); #1;
    chk(colSync == 1'b0 && crsSync == 1'b1, "R9", "col/crs after one edge",
        {colSync, crsSync}, 1);
    @(posedge clk); #1;
    chk(colSync == 1'b1 && crsSync == 1'b0, "R9", "col/crs after two edges",
        {colSync, crsSync}, 2);
    @(negedge clk); colIn = 1'b0;
    idle(3);
  endtask

  initial begin
    testReset();
    idle(2);
    testBasic();
    testRxErr();
    testOdd();
    testNoSfd();
    testIgnoreIdle();
    testSingleByte();
    testBackToBack();
    testSync();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule